// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the status byte of a serial flash device and rules on every instruction that an upstream command decoder hands it. The decoder raises one strobe per decoded instruction (write enable, write disable, read status, write status, page program, sector erase, block erase, chip erase). In the same cycle the block answers with accept or reject, so the decoder knows whether to go on with the array access. Program, erase and status-write operations are timed by an internal down-counter, one duration parameter per operation type. While that counter runs, the busy bit is set.

The status byte is driven continuously. Bit 0 is busy, bit 1 is the write-enable latch, bits 4..2 are the block-protect field, bit 5 selects top (0) or bottom (1) protection, bit 6 is reserved and bit 7 is the status-register lock bit. While the lock bit is 1 and the active-low write-protect pin is low, the protection fields are frozen.

Top module: `flash_status_ctrl`

## Requirements
- R1: After a synchronous reset the status byte reads 0x00, busy is 0, and with no strobe raised neither accept nor reject is asserted.
- R2: When idle, an accepted write-enable strobe sets status bit 1 from the next clock edge on. An accepted write-disable strobe clears it from the next edge on.
- R3: With bit 1 set and busy clear, write status, page program, sector erase, block erase and chip erase are accepted. On the next edge bit 1 clears and busy (status bit 0 and the busy port) rises. Busy stays high for exactly WS_CYCLES, PP_CYCLES, SE_CYCLES, BE_CYCLES or CE_CYCLES cycles, according to the operation.
- R4: Write status, program and erase strobes raised while bit 1 is 0 are rejected. They leave the status byte unchanged and do not raise busy.
- R5: While busy is 1, every strobe except read status is rejected and changes nothing. Read status is accepted in every cycle, busy or not.
- R6: An accepted write status takes bits 7, 5, 4, 3 and 2 of the data byte into the same status positions. Data bits 6, 1 and 0 are ignored, and status bit 6 always reads 0.
- R7: If status bit 7 is 1 and wp_n is 0 when write status is accepted, bits 7 and 5..2 stay unchanged, although busy and the latch clear still follow R3. With wp_n at 1 the write takes effect.
- R8: A cycle with two or more strobes raised is rejected and has no effect on the status byte.
- R9: In every cycle, accept and reject are mutually exclusive, and exactly one of them is high whenever at least one strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Write-enable instruction strobe |
| cmd_wrdi | input | 1 | Write-disable instruction strobe |
| cmd_rdsr | input | 1 | Read-status instruction strobe |
| cmd_wrsr | input | 1 | Write-status instruction strobe |
| cmd_pp | input | 1 | Page-program instruction strobe |
| cmd_se | input | 1 | Sector-erase instruction strobe |
| cmd_be | input | 1 | Block-erase instruction strobe |
| cmd_ce | input | 1 | Chip-erase instruction strobe |
| wp_n | input | 1 | Write-protect pin, active low |
| wrsr_data | input | 8 | Data byte for write status |
| status_out | output | 8 | Live status byte |
| busy | output | 1 | Operation in progress (same as status bit 0) |
| cmd_accept | output | 1 | Strobe of this cycle is accepted |
| cmd_reject | output | 1 | Strobe of this cycle is rejected |

## Verification
Every stored bit is visible in status_out, so a wrong latch, protection or busy state appears at the ports one clock edge after the instruction that caused it. A counter that runs long or short shows up as busy falling on the wrong edge. That same fault also shows up as accept or reject on the wrong side of the first strobe after the operation. The bench follows a cycle-level reference model through directed sequences and a pseudo-random stream, compares the whole status byte together with accept and reject on every clock, and so catches any such error in the first cycle it becomes visible.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam int NUM_STROBES = 8;
    localparam int IDX_WREN = 0;
    localparam int IDX_WRDI = 1;
    localparam int IDX_RDSR = 2;
    localparam int IDX_WRSR = 3;
    localparam int IDX_PP   = 4;
    localparam int IDX_SE   = 5;
    localparam int IDX_BE   = 6;
    localparam int IDX_CE   = 7;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_WREN,
        OP_WRDI,
        OP_RDSR,
        OP_WRSR,
        OP_PP,
        OP_SE,
        OP_BE,
        OP_CE,
        OP_CLASH
    } op_e;

    // protection fields that survive in the status byte
    typedef struct packed {
        logic       lock;
        logic       bottom;
        logic [2:0] bp;
    } prot_t;

    typedef struct packed {
        logic       lock;
        logic       rsvd;
        logic       bottom;
        logic [2:0] bp;
        logic       wel;
        logic       busy;
    } status_t;

    function automatic op_e strobe_to_op(input int idx);
        case (idx)
            IDX_WREN: return OP_WREN;
            IDX_WRDI: return OP_WRDI;
            IDX_RDSR: return OP_RDSR;
            IDX_WRSR: return OP_WRSR;
            IDX_PP:   return OP_PP;
            IDX_SE:   return OP_SE;
            IDX_BE:   return OP_BE;
            IDX_CE:   return OP_CE;
            default:  return OP_NONE;
        endcase
    endfunction

    // operations that need the write-enable latch and occupy the device
    function automatic logic op_is_timed(input op_e op);
        return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
               (op == OP_BE) || (op == OP_CE);
    endfunction

    function automatic logic prot_frozen(input prot_t p, input logic wp_n);
        return p.lock & ~wp_n;
    endfunction

    function automatic prot_t prot_from_byte(input logic [7:0] d);
        prot_t p;
        p.lock   = d[7];
        p.bottom = d[5];
        p.bp     = d[4:2];
        return p;
    endfunction

    function automatic status_t build_status(input prot_t p, input logic wel,
                                             input logic busy);
        status_t s;
        s.lock   = p.lock;
        s.rsvd   = 1'b0;
        s.bottom = p.bottom;
        s.bp     = p.bp;
        s.wel    = wel;
        s.busy   = busy;
        return s;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_sr_decode.sv
module flash_sr_decode
    import flash_sr_pkg::*;
(
    input  logic [NUM_STROBES-1:0] strobes,
    output op_e                    op
);
    localparam int CNT_W = $clog2(NUM_STROBES + 1);

    logic [CNT_W-1:0] n_raised;
    op_e              single_op;

    always_comb begin
        n_raised  = '0;
        single_op = OP_NONE;
        for (int i = 0; i < NUM_STROBES; i++) begin
            if (strobes[i]) begin
                n_raised  = n_raised + CNT_W'(1);
                single_op = strobe_to_op(i);
            end
        end
    end

    always_comb begin
        if (n_raised == '0)
            op = OP_NONE;
        else if (n_raised == CNT_W'(1))
            op = single_op;
        else
            op = OP_CLASH;
    end
endmodule

// File: rtl/flash_sr_gate.sv
module flash_sr_gate
    import flash_sr_pkg::*;
(
    input  op_e  op,
    input  logic busy,
    input  logic wel,
    output logic accept,
    output logic reject,
    output op_e  go_op
);
    always_comb begin
        accept = 1'b0;
        reject = 1'b0;
        go_op  = OP_NONE;
        case (op)
            OP_NONE: ;
            OP_CLASH: reject = 1'b1;
            OP_RDSR: begin
                accept = 1'b1;
                go_op  = OP_RDSR;
            end
            default: begin
                if (busy) begin
                    reject = 1'b1;
                end else if (op_is_timed(op) && !wel) begin
                    reject = 1'b1;
                end else begin
                    accept = 1'b1;
                    go_op  = op;
                end
            end
        endcase
    end
endmodule

// File: rtl/flash_sr_timer.sv
module flash_sr_timer
    import flash_sr_pkg::*;
#(
    parameter int PP_CYCLES = 8,
    parameter int SE_CYCLES = 40,
    parameter int BE_CYCLES = 80,
    parameter int CE_CYCLES = 200,
    parameter int WS_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  op_e  go_op,
    output logic busy
);
    // durations below one cycle are raised to one
    localparam int D_PP = (PP_CYCLES < 1) ? 1 : PP_CYCLES;
    localparam int D_SE = (SE_CYCLES < 1) ? 1 : SE_CYCLES;
    localparam int D_BE = (BE_CYCLES < 1) ? 1 : BE_CYCLES;
    localparam int D_CE = (CE_CYCLES < 1) ? 1 : CE_CYCLES;
    localparam int D_WS = (WS_CYCLES < 1) ? 1 : WS_CYCLES;
    localparam int D_MAX = max_of(max_of(max_of(D_PP, D_SE), max_of(D_BE, D_CE)), D_WS);
    localparam int CW = (D_MAX < 2) ? 1 : $clog2(D_MAX);

    logic [CW-1:0] remain;
    logic [CW-1:0] load_val;

    always_comb begin
        case (go_op)
            OP_PP:   load_val = CW'(D_PP - 1);
            OP_SE:   load_val = CW'(D_SE - 1);
            OP_BE:   load_val = CW'(D_BE - 1);
            OP_CE:   load_val = CW'(D_CE - 1);
            OP_WRSR: load_val = CW'(D_WS - 1);
            default: load_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0)
                busy <= 1'b0;
            else
                remain <= remain - CW'(1);
        end else if (op_is_timed(go_op)) begin
            busy   <= 1'b1;
            remain <= load_val;
        end
    end
endmodule

// File: rtl/flash_sr_regs.sv
module flash_sr_regs
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_e        go_op,
    input  logic       wp_n,
    input  logic [7:0] wr_data,
    output prot_t      prot,
    output logic       wel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= '0;
            wel  <= 1'b0;
        end else begin
            case (go_op)
                OP_WREN: wel <= 1'b1;
                OP_WRDI: wel <= 1'b0;
                OP_WRSR: begin
                    wel <= 1'b0;
                    if (!prot_frozen(prot, wp_n))
                        prot <= prot_from_byte(wr_data);
                end
                OP_PP, OP_SE, OP_BE, OP_CE: wel <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import flash_sr_pkg::*;
#(
    parameter int PP_CYCLES = 8,
    parameter int SE_CYCLES = 40,
    parameter int BE_CYCLES = 80,
    parameter int CE_CYCLES = 200,
    parameter int WS_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_rdsr,
    input  logic       cmd_wrsr,
    input  logic       cmd_pp,
    input  logic       cmd_se,
    input  logic       cmd_be,
    input  logic       cmd_ce,
    input  logic       wp_n,
    input  logic [7:0] wrsr_data,
    output logic [7:0] status_out,
    output logic       busy,
    output logic       cmd_accept,
    output logic       cmd_reject
);
    logic [NUM_STROBES-1:0] strobes;
    op_e     dec_op;
    op_e     go_op;
    prot_t   prot;
    logic    wel;
    logic    busy_q;
    status_t status;

    always_comb begin
        strobes           = '0;
        strobes[IDX_WREN] = cmd_wren;
        strobes[IDX_WRDI] = cmd_wrdi;
        strobes[IDX_RDSR] = cmd_rdsr;
        strobes[IDX_WRSR] = cmd_wrsr;
        strobes[IDX_PP]   = cmd_pp;
        strobes[IDX_SE]   = cmd_se;
        strobes[IDX_BE]   = cmd_be;
        strobes[IDX_CE]   = cmd_ce;
    end

    flash_sr_decode u_decode (
        .strobes (strobes),
        .op      (dec_op)
    );

    flash_sr_gate u_gate (
        .op     (dec_op),
        .busy   (busy_q),
        .wel    (wel),
        .accept (cmd_accept),
        .reject (cmd_reject),
        .go_op  (go_op)
    );

    flash_sr_timer #(
        .PP_CYCLES (PP_CYCLES),
        .SE_CYCLES (SE_CYCLES),
        .BE_CYCLES (BE_CYCLES),
        .CE_CYCLES (CE_CYCLES),
        .WS_CYCLES (WS_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .go_op (go_op),
        .busy  (busy_q)
    );

    flash_sr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .go_op   (go_op),
        .wp_n    (wp_n),
        .wr_data (wrsr_data),
        .prot    (prot),
        .wel     (wel)
    );

    assign status     = build_status(prot, wel, busy_q);
    assign status_out = status;
    assign busy       = busy_q;
endmodule

// File: rtl/flash_status_ctrl_chk.sv
module flash_status_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_rdsr,
    input logic       cmd_wrsr,
    input logic       cmd_pp,
    input logic       cmd_se,
    input logic       cmd_be,
    input logic       cmd_ce,
    input logic       wp_n,
    input logic [7:0] wrsr_data,
    input logic [7:0] status_out,
    input logic       busy,
    input logic       cmd_accept,
    input logic       cmd_reject
);
    logic [7:0] stb;
    logic       timed_stb;
    assign stb = {cmd_ce, cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_rdsr, cmd_wrdi, cmd_wren};
    assign timed_stb = cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;

    // R2: accepted write enable sets the latch
    a_r2_wel_set: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept && $countones(stb) == 1 && cmd_wren) |=> status_out[1]);

    // R3: accepted timed operation raises busy and clears the latch
    a_r3_busy_start: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept && $countones(stb) == 1 && timed_stb) |=> (busy && !status_out[1]));

    // R4: timed operation without the latch is refused
    a_r4_need_wel: assert property (@(posedge clk) disable iff (rst)
        ($countones(stb) == 1 && timed_stb && !busy && !status_out[1]) |-> cmd_reject);

    // R5: only status reads get through while busy
    a_r5_busy_gate: assert property (@(posedge clk) disable iff (rst)
        (busy && $countones(stb) == 1 && !cmd_rdsr) |-> cmd_reject);

    a_r5_rdsr_ok: assert property (@(posedge clk) disable iff (rst)
        ($countones(stb) == 1 && cmd_rdsr) |-> cmd_accept);

    // R6: reserved bit and write-through of data bits
    a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        !status_out[6]);

    a_r6_write_through: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept && $countones(stb) == 1 && cmd_wrsr && (wp_n || !status_out[7]))
        |=> (status_out[5:2] == $past(wrsr_data[5:2]) && status_out[7] == $past(wrsr_data[7])));

    // R7: lock with pin low freezes the protection fields
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept && cmd_wrsr && status_out[7] && !wp_n) |=> $stable(status_out[7:2]));

    // R8: simultaneous strobes are refused
    a_r8_clash: assert property (@(posedge clk) disable iff (rst)
        ($countones(stb) > 1) |-> cmd_reject);

    // R9: accept and reject are exclusive, one of them answers any strobe
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_reject));

    a_r9_answer: assert property (@(posedge clk) disable iff (rst)
        (stb != 8'h00) == (cmd_accept || cmd_reject));
endmodule

bind flash_status_ctrl flash_status_ctrl_chk u_chk (.*);

// File: tb/flash_status_ctrl_test.sv
`timescale 1ns/1ps
module flash_status_ctrl_test;
    localparam int T_PP = 3;
    localparam int T_SE = 5;
    localparam int T_BE = 7;
    localparam int T_CE = 9;
    localparam int T_WS = 4;

    // strobe vector positions used by the bench
    localparam logic [7:0] S_WREN = 8'h01;
    localparam logic [7:0] S_WRDI = 8'h02;
    localparam logic [7:0] S_RDSR = 8'h04;
    localparam logic [7:0] S_WRSR = 8'h08;
    localparam logic [7:0] S_PP   = 8'h10;
    localparam logic [7:0] S_SE   = 8'h20;
    localparam logic [7:0] S_BE   = 8'h40;
    localparam logic [7:0] S_CE   = 8'h80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] stb = 8'h00;
    logic       wp_n = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] status_out;
    logic       busy;
    logic       cmd_accept;
    logic       cmd_reject;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    int m_busy_left = 0;
    bit m_wel = 0;
    bit m_lock = 0;
    bit m_bottom = 0;
    int m_bp = 0;

    always #2.5 clk = ~clk;

    flash_status_ctrl #(
        .PP_CYCLES (T_PP), .SE_CYCLES (T_SE), .BE_CYCLES (T_BE),
        .CE_CYCLES (T_CE), .WS_CYCLES (T_WS)
    ) uut (
        .clk (clk), .rst (rst),
        .cmd_wren (stb[0]), .cmd_wrdi (stb[1]), .cmd_rdsr (stb[2]), .cmd_wrsr (stb[3]),
        .cmd_pp (stb[4]), .cmd_se (stb[5]), .cmd_be (stb[6]), .cmd_ce (stb[7]),
        .wp_n (wp_n), .wrsr_data (wdata),
        .status_out (status_out), .busy (busy),
        .cmd_accept (cmd_accept), .cmd_reject (cmd_reject)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_status();
        logic [7:0] s;
        s[7]   = m_lock;
        s[6]   = 1'b0;
        s[5]   = m_bottom;
        s[4:2] = m_bp[2:0];
        s[1]   = m_wel;
        s[0]   = (m_busy_left > 0);
        return s;
    endfunction

    function automatic int op_time(input logic [7:0] s);
        case (s)
            S_WRSR:  return T_WS;
            S_PP:    return T_PP;
            S_SE:    return T_SE;
            S_BE:    return T_BE;
            default: return T_CE;
        endcase
    endfunction

    task automatic step(input logic [7:0] s, input logic [7:0] d, input logic wp,
                        input string req);
        bit exp_acc;
        bit exp_rej;
        bit timed;
        @(negedge clk);
        stb = s; wdata = d; wp_n = wp;
        #1;
        timed = (s == S_WRSR) || (s == S_PP) || (s == S_SE) || (s == S_BE) || (s == S_CE);
        exp_acc = 0; exp_rej = 0;
        if (s == 8'h00) begin
        end else if ($countones(s) > 1) exp_rej = 1;
        else if (s == S_RDSR) exp_acc = 1;
        else if (m_busy_left > 0) exp_rej = 1;
        else if (timed && !m_wel) exp_rej = 1;
        else exp_acc = 1;
        check(req, "status", status_out, model_status());
        check(req, "busy", {7'b0, busy}, {7'b0, m_busy_left > 0});
        check(req, "accept", {7'b0, cmd_accept}, {7'b0, exp_acc});
        check(req, "reject", {7'b0, cmd_reject}, {7'b0, exp_rej});
        @(posedge clk);
        if (m_busy_left > 0) m_busy_left--;
        if (exp_acc) begin
            if (s == S_WREN) m_wel = 1;
            else if (s == S_WRDI) m_wel = 0;
            else if (timed) begin
                m_wel = 0;
                m_busy_left = op_time(s);
                if (s == S_WRSR && !(m_lock && !wp)) begin
                    m_lock = d[7]; m_bottom = d[5]; m_bp = int'(d[4:2]);
                end
            end
        end
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(8'h00, 8'h00, 1'b1, req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        step(8'h00, 8'h00, 1'b1, "R1");

        // R4: no latch, timed ops refused
        step(S_WRSR, 8'hFF, 1'b1, "R4");
        step(S_PP, 8'h00, 1'b1, "R4");
        step(S_CE, 8'h00, 1'b1, "R4");
        step(8'h00, 8'h00, 1'b1, "R4");

        // R2: latch set and clear
        step(S_WREN, 8'h00, 1'b1, "R2");
        step(S_WRDI, 8'h00, 1'b1, "R2");
        step(S_RDSR, 8'h00, 1'b1, "R2");
        step(S_WREN, 8'h00, 1'b1, "R2");

        // R6: write all ones, reserved and low bits ignored
        step(S_WRSR, 8'hFF, 1'b1, "R6");
        // R5: while busy only reads pass
        step(S_WREN, 8'h00, 1'b1, "R5");
        step(S_RDSR, 8'h00, 1'b1, "R5");
        step(S_PP, 8'h00, 1'b1, "R5");
        step(S_WRDI, 8'h00, 1'b1, "R5");
        idle(T_WS, "R3");

        // R7: locked and pin low -> frozen
        step(S_WREN, 8'h00, 1'b0, "R7");
        step(S_WRSR, 8'h00, 1'b0, "R7");
        idle(T_WS + 1, "R7");
        // R7: pin high -> writes go through
        step(S_WREN, 8'h00, 1'b1, "R7");
        step(S_WRSR, 8'h20, 1'b1, "R7");
        idle(T_WS + 1, "R7");
        step(S_WREN, 8'h00, 1'b1, "R6");
        step(S_WRSR, 8'h5B, 1'b0, "R6");
        idle(T_WS + 1, "R6");

        // R3: every timed op and its duration
        step(S_WREN, 8'h00, 1'b1, "R3"); step(S_PP, 8'h00, 1'b1, "R3"); idle(T_PP + 1, "R3");
        step(S_WREN, 8'h00, 1'b1, "R3"); step(S_SE, 8'h00, 1'b1, "R3"); idle(T_SE + 1, "R3");
        step(S_WREN, 8'h00, 1'b1, "R3"); step(S_BE, 8'h00, 1'b1, "R3"); idle(T_BE + 1, "R3");
        step(S_WREN, 8'h00, 1'b1, "R3"); step(S_CE, 8'h00, 1'b1, "R3"); idle(T_CE + 1, "R3");

        // R8: clashes
        step(S_WREN | S_WRDI, 8'h00, 1'b1, "R8");
        step(S_WREN | S_RDSR, 8'h00, 1'b1, "R8");
        step(S_WREN, 8'h00, 1'b1, "R8");
        step(S_WRSR | S_PP, 8'hFF, 1'b1, "R8");
        step(8'h00, 8'h00, 1'b1, "R8");

        // R9: pseudo-random stream against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] s;
            int pick;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pick = int'(lfsr[3:0]) % 11;
            if (pick < 8) s = 8'h01 << pick;
            else if (pick == 8) s = S_WREN;
            else if (pick == 9) s = 8'h00;
            else s = (8'h01 << lfsr[6:4]) | (8'h01 << ((int'(lfsr[6:4]) + 1) % 8));
            step(s, lfsr[15:8], lfsr[7] | lfsr[9], "R9");
        end

        // R1: reset again from a busy state
        step(S_WREN, 8'h00, 1'b1, "R1");
        step(S_CE, 8'h00, 1'b1, "R1");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_busy_left = 0; m_wel = 0; m_lock = 0; m_bottom = 0; m_bp = 0;
        step(8'h00, 8'h00, 1'b1, "R1");

        done = 1;
        finish_run();
    end
endmodule